// File: doc/BRIEF.md
# CRT Character Timing Generator

This block is the timing core of a character-cell video controller. The clock is the character clock. A horizontal counter steps through the character positions of a line. A scanline counter and a row counter then divide the frame into text rows of programmable height, and a separate run of extra scanlines can be added at the bottom of the frame. From these counters the block produces horizontal sync, vertical sync, a display-enable window and a one-cycle frame-start marker.

Software sets the timing through two accesses at one write port. The first access selects a register number and the second writes the value. A new value is used at the next comparison that needs it, and no write restarts a counter. Vertical sync runs for a fixed sixteen scanlines. If the frame ends before those sixteen scanlines are complete, the sync ends with the frame.

With the reset values the block produces a 57-character line and a 262-scanline frame. At a 14.318 MHz dot clock with 16 dots per character, that is 912 dots per line and a frame rate close to 59.92 Hz. Shortening the frame by one scanline raises the rate to about 60.15 Hz.

Top module: `crtc_timing`

## Requirements
- R1: While reset is held, and in the first cycle after it, the outputs are frame_start=1, disp_en=1, hsync=0 and vsync=0. Reset loads these register values: index 0=0x38, 1=0x28, 2=0x2D, 3=0x0A, 4=0x1F, 5=0x06, 6=0x19, 7=0x1C, 9=0x07.
- R2: A write with reg_sel=0 selects a register index taken from reg_wdata[3:0]. A write with reg_sel=1 stores reg_wdata into the selected register. The index map is: 0 = last character of the line, 1 = displayed characters, 2 = hsync start character, 3 = hsync width, 4 = last row of the frame, 5 = adjust scanlines, 6 = displayed rows, 7 = vsync row, 9 = last scanline within a row. A write never restarts the counters.
- R3: A line lasts reg0+1 clocks. hsync is high on the characters h with reg2 <= h < reg2+reg3 that fall inside the line. A width of 0 gives no hsync.
- R4: In the horizontal direction the display window covers characters 0 to reg1-1 of each line.
- R5: A frame lasts (reg4+1)*(reg9+1)+reg5 lines. frame_start is high only in the first clock of each frame.
- R6: Rows below reg6 are active and all other rows, including the adjust scanlines, are overscan. disp_en is high only where both the horizontal window and the vertical window are active.
- R7: vsync rises at the first clock of line reg7*(reg9+1) of the frame and stays high for 16 whole lines. It changes only at line boundaries. If reg7 is greater than reg4, there is no vsync.
- R8: If the frame ends while vsync is high, vsync falls at the frame boundary and is low in the frame_start clock.
- R9: With reg5=0 there are no adjust scanlines, and the frame is exactly (reg4+1)*(reg9+1) lines long.
- R10: Data writes while index 8 or any index from 10 to 15 is selected change nothing.
- R11: The reset values give a 262-line frame of 57-clock lines. vsync starts on line 224, and the display window is 40 characters by 200 lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register port write strobe |
| reg_sel | input | 1 | 0 selects an index, 1 writes data to the selected register |
| reg_wdata | input | 8 | Index or data value |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Display-enable window |
| frame_start | output | 1 | High in the first clock of each frame |

## Verification
Two events can fall on the same line boundary: the frame wrap and a vertical sync that is still running. The wrap has to win. Several configurations in the bench place the sync row so close to the bottom of the frame that the 16-line window runs past the end of the frame. In those cases the bench compares the total vsync clocks with the lines actually left in the frame, and checks that vsync is already low in the frame_start clock. A second coincidence is a register write landing in the middle of a frame. The bench judges it by checking that the length of that frame is unchanged.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int CRTC_DW    = 8;
  localparam int CRTC_IW    = 4;
  localparam int CRTC_NSLOT = 9;

  typedef logic [CRTC_DW-1:0] cval_t;

  typedef enum logic [CRTC_IW-1:0] {
    IX_LINE_LAST = 4'd0,
    IX_H_SHOWN   = 4'd1,
    IX_HS_START  = 4'd2,
    IX_HS_WIDTH  = 4'd3,
    IX_ROW_LAST  = 4'd4,
    IX_ADJ_LINES = 4'd5,
    IX_V_SHOWN   = 4'd6,
    IX_VS_ROW    = 4'd7,
    IX_ROW_H     = 4'd9
  } crtc_idx_e;

  typedef struct packed {
    cval_t line_last;
    cval_t h_shown;
    cval_t hs_start;
    cval_t hs_width;
    cval_t row_last;
    cval_t adj_lines;
    cval_t v_shown;
    cval_t vs_row;
    cval_t row_h;
  } crtc_regs_t;

  // storage slot -> register index
  function automatic crtc_idx_e slot_index(input int s);
    case (s)
      0:       return IX_LINE_LAST;
      1:       return IX_H_SHOWN;
      2:       return IX_HS_START;
      3:       return IX_HS_WIDTH;
      4:       return IX_ROW_LAST;
      5:       return IX_ADJ_LINES;
      6:       return IX_V_SHOWN;
      7:       return IX_VS_ROW;
      default: return IX_ROW_H;
    endcase
  endfunction

  // reset contents: 40-column text timing, 262 lines
  function automatic cval_t slot_default(input int s);
    case (s)
      0:       return 8'h38;
      1:       return 8'h28;
      2:       return 8'h2D;
      3:       return 8'h0A;
      4:       return 8'h1F;
      5:       return 8'h06;
      6:       return 8'h19;
      7:       return 8'h1C;
      default: return 8'h07;
    endcase
  endfunction

  // pos inside [start, start+len), computed one bit wider
  function automatic logic in_window(input cval_t pos, input cval_t start, input cval_t len);
    logic [CRTC_DW:0] p, s, e;
    p = {1'b0, pos};
    s = {1'b0, start};
    e = s + {1'b0, len};
    return (p >= s) && (p < e);
  endfunction

  // true when cnt is the last step of a run of `limit` steps
  function automatic logic run_done(input cval_t cnt, input cval_t limit);
    return ({1'b0, cnt} + (CRTC_DW+1)'(1)) >= {1'b0, limit};
  endfunction
endpackage

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       sel,
  input  cval_t      wdata,
  output crtc_regs_t regs
);
  logic [CRTC_IW-1:0] idx_q;
  cval_t              val [CRTC_NSLOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx_q <= '0;
    else if (wr && !sel) idx_q <= wdata[CRTC_IW-1:0];
  end

  // one storage slot per implemented index; other indices have no slot
  for (genvar g = 0; g < CRTC_NSLOT; g++) begin : g_slot
    localparam crtc_idx_e MY_IX = slot_index(g);
    logic  hit;
    cval_t q;
    assign hit = wr && sel && (idx_q == MY_IX);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= slot_default(g);
      else if (hit) q <= wdata;
    end
    assign val[g] = q;
  end

  assign regs.line_last = val[0];
  assign regs.h_shown   = val[1];
  assign regs.hs_start  = val[2];
  assign regs.hs_width  = val[3];
  assign regs.row_last  = val[4];
  assign regs.adj_lines = val[5];
  assign regs.v_shown   = val[6];
  assign regs.vs_row    = val[7];
  assign regs.row_h     = val[8];
endmodule

// File: rtl/crtc_hcount.sv
module crtc_hcount
  import crtc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  cval_t line_last,
  input  cval_t h_shown,
  input  cval_t hs_start,
  input  cval_t hs_width,
  output cval_t h_pos,
  output logic  line_end,
  output logic  h_active,
  output logic  hsync
);
  // >= keeps the line bounded if the limit drops below the count
  assign line_end = (h_pos >= line_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        h_pos <= '0;
    else if (line_end) h_pos <= '0;
    else               h_pos <= h_pos + cval_t'(1);
  end

  assign h_active = (h_pos < h_shown);
  assign hsync    = in_window(h_pos, hs_start, hs_width);
endmodule

// File: rtl/crtc_vcount.sv
module crtc_vcount
  import crtc_pkg::*;
#(
  parameter int VSYNC_LINES = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  line_end,
  input  cval_t row_last,
  input  cval_t adj_lines,
  input  cval_t v_shown,
  input  cval_t vs_row,
  input  cval_t row_h,
  output logic  v_active,
  output logic  vsync,
  output logic  at_origin,
  output logic  frame_wrap
);
  localparam int VS_W = (VSYNC_LINES > 1) ? $clog2(VSYNC_LINES) : 1;

  cval_t sl, row, adj;
  logic  in_adj;
  cval_t sl_n, row_n, adj_n;
  logic  in_adj_n;
  logic  last_sl, rows_done, vs_hit;
  logic  vs_on;
  logic [VS_W-1:0] vs_cnt;

  assign last_sl    = (sl >= row_h);
  assign rows_done  = last_sl && (row >= row_last);
  assign frame_wrap = line_end &&
                      (in_adj ? run_done(adj, adj_lines) : (rows_done && (adj_lines == '0)));
  // entering the first scanline of the sync row
  assign vs_hit     = line_end && !in_adj && last_sl && !rows_done &&
                      ((row + cval_t'(1)) == vs_row);

  always_comb begin
    sl_n     = sl;
    row_n    = row;
    adj_n    = adj;
    in_adj_n = in_adj;
    if (frame_wrap) begin
      sl_n     = '0;
      row_n    = '0;
      adj_n    = '0;
      in_adj_n = 1'b0;
    end else if (line_end) begin
      if (in_adj) begin
        adj_n = adj + cval_t'(1);
      end else if (!last_sl) begin
        sl_n = sl + cval_t'(1);
      end else begin
        sl_n = '0;
        if (rows_done) begin
          in_adj_n = 1'b1;
          adj_n    = '0;
        end else begin
          row_n = row + cval_t'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sl     <= '0;
      row    <= '0;
      adj    <= '0;
      in_adj <= 1'b0;
    end else begin
      sl     <= sl_n;
      row    <= row_n;
      adj    <= adj_n;
      in_adj <= in_adj_n;
    end
  end

  // fixed-length sync; the frame boundary takes priority over everything
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_on  <= 1'b0;
      vs_cnt <= '0;
    end else if (frame_wrap) begin
      vs_on  <= 1'b0;
      vs_cnt <= '0;
    end else if (vs_hit) begin
      vs_on  <= 1'b1;
      vs_cnt <= '0;
    end else if (line_end && vs_on) begin
      if (vs_cnt == VS_W'(VSYNC_LINES - 1)) vs_on  <= 1'b0;
      else                                  vs_cnt <= vs_cnt + VS_W'(1);
    end
  end

  assign vsync     = vs_on;
  assign v_active  = !in_adj && (row < v_shown);
  assign at_origin = !in_adj && (row == '0) && (sl == '0);
endmodule

// File: rtl/crtc_timing.sv
module crtc_timing
  import crtc_pkg::*;
#(
  parameter int VSYNC_LINES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_sel,
  input  logic [CRTC_DW-1:0] reg_wdata,
  output logic               hsync,
  output logic               vsync,
  output logic               disp_en,
  output logic               frame_start
);
  crtc_regs_t regs;
  cval_t      h_pos;
  logic       line_end, h_active, v_active, at_origin, frame_wrap;

  crtc_regfile u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .sel   (reg_sel),
    .wdata (reg_wdata),
    .regs  (regs)
  );

  crtc_hcount u_h (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_last (regs.line_last),
    .h_shown   (regs.h_shown),
    .hs_start  (regs.hs_start),
    .hs_width  (regs.hs_width),
    .h_pos     (h_pos),
    .line_end  (line_end),
    .h_active  (h_active),
    .hsync     (hsync)
  );

  crtc_vcount #(.VSYNC_LINES(VSYNC_LINES)) u_v (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_end   (line_end),
    .row_last   (regs.row_last),
    .adj_lines  (regs.adj_lines),
    .v_shown    (regs.v_shown),
    .vs_row     (regs.vs_row),
    .row_h      (regs.row_h),
    .v_active   (v_active),
    .vsync      (vsync),
    .at_origin  (at_origin),
    .frame_wrap (frame_wrap)
  );

  assign frame_start = at_origin && (h_pos == '0);
  assign disp_en     = h_active && v_active;
endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk #(
  parameter int VSYNC_LINES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       line_end,
  input logic       frame_wrap,
  input logic       frame_start,
  input logic       vsync,
  input logic [7:0] h_pos
);
  localparam int CW = $clog2(VSYNC_LINES) + 1;

  logic          live;
  logic [CW-1:0] vs_lines;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vs_lines <= '0;
    else if (line_end) vs_lines <= vsync ? (vs_lines + CW'(1)) : '0;
  end

  // R5
  frame_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && frame_start) |-> $past(frame_wrap));

  // R8
  wrap_clears_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !vsync);

  // R7
  vsync_line_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$stable(vsync)) |-> $past(line_end));

  // R7
  vsync_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && line_end) |-> (vs_lines < CW'(VSYNC_LINES)));

  // R2
  h_steady_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(line_end)) |-> (h_pos == 8'($past(h_pos) + 8'd1)));
endmodule

bind crtc_timing crtc_timing_chk #(.VSYNC_LINES(VSYNC_LINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_end    (line_end),
  .frame_wrap  (frame_wrap),
  .frame_start (frame_start),
  .vsync       (vsync),
  .h_pos       (h_pos)
);

// File: tb/sim_crtc_timing.sv
`timescale 1ns/1ps
module sim_crtc_timing;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       hsync, vsync, disp_en, frame_start;

  int n_checks = 0;
  int n_errors = 0;
  int run_len  = 0;
  int last_len = 0;

  always #10 clk = ~clk;

  crtc_timing u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .hsync       (hsync),
    .vsync       (vsync),
    .disp_en     (disp_en),
    .frame_start (frame_start)
  );

  // columns: r0 r1 r2 r3 r4 r5 r6 r7 r9 | lines vs_line vs_len (-1: no sync)
  localparam int NV = 7;
  localparam int TBL [NV][12] = '{
    '{9, 6, 7, 2,  4, 3,  3,  2, 2,  18,  6, 12},
    '{7, 8, 3, 4,  5, 0,  6,  1, 1,  12,  2, 10},
    '{5, 2, 4, 5,  3, 2,  1,  3, 1,  10,  6,  4},
    '{3, 1, 1, 1,  9, 5,  8,  2, 3,  45,  8, 16},
    '{4, 3, 0, 1, 19, 1, 10, 15, 0,  21, 15,  6},
    '{6, 4, 5, 0,  2, 4,  2,  1, 2,  13,  3, 10},
    '{5, 3, 2, 2,  2, 1,  2,  5, 1,   7, -1,  0}
  };

  // frame length monitor
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len  <= 0;
      last_len <= 0;
    end else if (frame_start) begin
      last_len <= run_len;
      run_len  <= 1;
    end else begin
      run_len <= run_len + 1;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input int v);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_sel   = sel;
    reg_wdata = 8'(v);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic setreg(input int idx, input int v);
    wr(1'b0, idx);
    wr(1'b1, v);
  endtask

  task automatic load_cfg(input int i);
    for (int k = 0; k < 8; k++) setreg(k, TBL[i][k]);
    setreg(9, TBL[i][8]);
  endtask

  task automatic wait_fs();
    do @(negedge clk); while (!frame_start);
  endtask

  task automatic measure(output int clks, output int de, output int hs,
                         output int vs, output int vsf, output int vs_at0);
    wait_fs();
    clks = 0; de = 0; hs = 0; vs = 0; vsf = -1;
    vs_at0 = int'(vsync);
    do begin
      if (disp_en) de++;
      if (hsync) hs++;
      if (vsync) begin
        vs++;
        if (vsf < 0) vsf = clks;
      end
      clks++;
      @(negedge clk);
    end while (!frame_start && clks < 40000);
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int exp_de(input int i);
    return imin(TBL[i][1], TBL[i][0] + 1) * imin(TBL[i][6], TBL[i][4] + 1) * (TBL[i][8] + 1);
  endfunction

  function automatic int exp_hs(input int i);
    if (TBL[i][2] > TBL[i][0]) return 0;
    return (imin(TBL[i][2] + TBL[i][3], TBL[i][0] + 1) - TBL[i][2]) * TBL[i][9];
  endfunction

  task automatic check_default(input string tag);
    int c, d, h, v, f, z;
    measure(c, d, h, v, f, z);
    chk({tag, " frame clocks"}, c, 262 * 57);
    chk({tag, " vsync first clock"}, f, 224 * 57);
    chk({tag, " vsync clocks"}, v, 16 * 57);
    chk({tag, " display clocks"}, d, 40 * 200);
    chk({tag, " hsync clocks"}, h, 262 * 10);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : main
    int c, d, h, v, f, z;
    repeat (3) @(negedge clk);
    // R1: outputs while in reset
    chk("R1 frame_start in reset", int'(frame_start), 1);
    chk("R1 disp_en in reset", int'(disp_en), 1);
    chk("R1 hsync in reset", int'(hsync), 0);
    chk("R1 vsync in reset", int'(vsync), 0);
    rst_n = 1'b1;

    // R11: reset timing
    check_default("R11");

    // vector table
    for (int i = 0; i < NV; i++) begin
      load_cfg(i);
      measure(c, d, h, v, f, z);
      chk((TBL[i][5] == 0) ? "R9 frame clocks" : "R5 frame clocks", c, TBL[i][9] * (TBL[i][0] + 1));
      chk("R4 R6 display clocks", d, exp_de(i));
      chk("R3 hsync clocks", h, exp_hs(i));
      chk("R7 vsync first clock", f, (TBL[i][10] < 0) ? -1 : TBL[i][10] * (TBL[i][0] + 1));
      chk((TBL[i][10] >= 0 && TBL[i][10] + 16 > TBL[i][9]) ? "R8 vsync clocks" : "R7 vsync clocks",
          v, TBL[i][11] * (TBL[i][0] + 1));
      chk("R8 vsync low at frame start", z, 0);
    end

    // R2: write in the middle of a frame leaves the frame length alone
    load_cfg(0);
    wait_fs();
    setreg(6, 1);
    setreg(6, 3);
    wait_fs();
    #1;
    chk("R2 frame clocks across mid-frame write", last_len, 180);

    // R10: writes to unimplemented indices are ignored
    load_cfg(2);
    setreg(8, 8'hFF);
    setreg(14, 0);
    setreg(15, 1);
    measure(c, d, h, v, f, z);
    chk("R10 frame clocks after ignored writes", c, 60);
    chk("R10 hsync clocks after ignored writes", h, exp_hs(2));
    chk("R10 vsync first after ignored writes", f, 36);

    // R1: reset in mid-run restores register defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 frame_start after mid-run reset", int'(frame_start), 1);
    chk("R1 vsync after mid-run reset", int'(vsync), 0);
    @(negedge clk);
    rst_n = 1'b1;
    check_default("R1");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule